// File: doc/BRIEF.md
# Unsigned multiply-add unit with paired register writeback

This block executes one three-operand instruction. It takes two 64-bit register values and multiplies them as unsigned numbers. It then adds a third register value, zero-extended to 128 bits, to the product. The full 128-bit sum goes to two neighbouring registers: the low half to the named destination, and the high half to the register just above it. The high half of one instruction can serve as the addend of the next. A sequence of these instructions therefore forms a multi-word by one-word multiply, with the carry word passed along through the register file.

Instructions arrive as 32-bit words on a valid/ready stream. A word transfers on a rising edge where both `in_valid` and `in_ready` are high. While the unit is busy, `in_ready` is low and the producer must hold its word. A word offered while `in_ready` is low has no effect. The unit decodes the word and reads all three sources in the accept cycle. It writes the low half one cycle later and the high half the cycle after that. It then pulses `done`. A malformed word is rejected with a one-cycle `illegal` pulse, and the unit stays ready. A debug port reads any register combinationally and presets registers while the unit is idle.

Top module: `mac_pair_unit`

## Requirements
- R1: Bit fields of the word are: primary opcode at [31:26], destination D at [25:21], first factor A at [20:16], second factor B at [15:11], addend C at [10:6], and extended opcode at [5:0]. A word is legal when [31:26] equals PRI_OP (default 4), [5:0] equals EXT_OP (default 50), and D is not 31.
- R2: After a legal word, register D holds bits 63..0 of A*B+C, with A and B taken as unsigned 64-bit values.
- R3: Register D+1 holds bits 127..64 of the same sum. The sum never overflows: with all three operands all-ones, D+1 becomes all-ones and D becomes zero.
- R4: The addend is zero-extended. An addend with bit 63 set and a zero product leaves D+1 at zero.
- R5: All three sources are read before either write, even when D or D+1 equals A, B or C.
- R6: A following word that names the previous D+1 as its addend uses the newly written high half.
- R7: A word with D=31 pulses `illegal` for one cycle. It writes no register, including registers 31 and 0, and `in_ready` stays high.
- R8: A word with a wrong primary or extended opcode pulses `illegal` for one cycle and writes no register.
- R9: After a legal accept, `in_ready` is low for exactly two cycles. `done` is high for one cycle together with the return of `in_ready`. A word offered while `in_ready` is low is ignored.
- R10: `dbg_rdata` shows register `dbg_addr` in the same cycle. `dbg_we` writes `dbg_wdata` only while `in_ready` is high and is ignored while the unit is busy.
- R11: After reset, `in_ready` is 1, `done` and `illegal` are 0, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_insn | input | 32 | Instruction word |
| done | output | 1 | One-cycle pulse after the high-half write |
| illegal | output | 1 | One-cycle pulse after a rejected word |
| dbg_we | input | 1 | Debug register write strobe |
| dbg_addr | input | 5 | Debug register index |
| dbg_wdata | input | 64 | Debug write data |
| dbg_rdata | output | 64 | Register contents at dbg_addr |

## Verification
The checker assumes the stream rule on the input side: a word counts only on an edge where `in_ready` is high. It also assumes that reset precedes any traffic, so that the write-port sequencing it watches (low half, then high half at the next index, then a single `done`) always starts from idle. The bench drives inputs only on falling edges. It holds `in_valid` until it sees `in_ready`, or, in the back-pressure test, deliberately drops it before `in_ready` returns. It issues debug presets only between instructions, except for the one directed test of a debug write made while the unit is busy.

// File: rtl/mac_pair_pkg.sv
package mac_pair_pkg;
  localparam int IDX_W = 5;
  localparam int NREG  = 1 << IDX_W;

  typedef struct packed {
    logic [5:0]       pri;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] fa;
    logic [IDX_W-1:0] fb;
    logic [IDX_W-1:0] add;
    logic [5:0]       ext;
  } insn_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WR_LO, ST_WR_HI} st_e;
endpackage

// File: rtl/mac_pair_decode.sv
module mac_pair_decode
  import mac_pair_pkg::*;
#(
  parameter logic [5:0] PRI_OP = 6'd4,
  parameter logic [5:0] EXT_OP = 6'd50
) (
  input  logic [31:0]      word,
  output logic [IDX_W-1:0] dst,
  output logic [IDX_W-1:0] dst_hi,
  output logic [IDX_W-1:0] fa,
  output logic [IDX_W-1:0] fb,
  output logic [IDX_W-1:0] add,
  output logic             legal
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

  insn_t f;
  assign f = insn_t'(word);

  always_comb begin
    dst    = f.dst;
    dst_hi = f.dst + IDX_W'(1);
    fa     = f.fa;
    fb     = f.fb;
    add    = f.add;
    legal  = (f.pri == PRI_OP) && (f.ext == EXT_OP) && (f.dst != LAST_IDX);
  end
endmodule

// File: rtl/mac_pair_rf.sv
module mac_pair_rf
  import mac_pair_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NPORT = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             waddr,
  input  logic [XLEN-1:0]              wdata,
  input  logic [NPORT-1:0][IDX_W-1:0]  raddr,
  output logic [NPORT-1:0][XLEN-1:0]   rdata
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/mac_pair_madd.sv
module mac_pair_madd #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   fa,
  input  logic [XLEN-1:0]   fb,
  input  logic [XLEN-1:0]   addend,
  output logic [2*XLEN-1:0] sum
);
  logic [2*XLEN-1:0] wa, wb, wc;

  always_comb begin
    wa  = {{XLEN{1'b0}}, fa};
    wb  = {{XLEN{1'b0}}, fb};
    wc  = {{XLEN{1'b0}}, addend};
    sum = wa * wb + wc;
  end
endmodule

// File: rtl/mac_pair_unit.sv
module mac_pair_unit
  import mac_pair_pkg::*;
#(
  parameter int         XLEN   = 64,
  parameter logic [5:0] PRI_OP = 6'd4,
  parameter logic [5:0] EXT_OP = 6'd50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_insn,
  output logic             done,
  output logic             illegal,
  input  logic             dbg_we,
  input  logic [IDX_W-1:0] dbg_addr,
  input  logic [XLEN-1:0]  dbg_wdata,
  output logic [XLEN-1:0]  dbg_rdata
);
  localparam int NPORT = 4;
  localparam int SW    = 2 * XLEN;

  st_e                       st_q;
  logic [SW-1:0]             sum_q;
  logic [IDX_W-1:0]          dst_q, dst_hi_q;
  logic                      done_q, ill_q;

  logic [IDX_W-1:0]          d_dst, d_dst_hi, d_fa, d_fb, d_add;
  logic                      d_legal;
  logic [NPORT-1:0][IDX_W-1:0] raddr;
  logic [NPORT-1:0][XLEN-1:0]  rdata;
  logic [SW-1:0]             sum_c;
  logic                      rf_we;
  logic [IDX_W-1:0]          rf_waddr;
  logic [XLEN-1:0]           rf_wdata;
  logic                      accept;

  mac_pair_decode #(.PRI_OP(PRI_OP), .EXT_OP(EXT_OP)) u_dec (
    .word(in_insn), .dst(d_dst), .dst_hi(d_dst_hi),
    .fa(d_fa), .fb(d_fb), .add(d_add), .legal(d_legal)
  );

  assign raddr[0] = d_fa;
  assign raddr[1] = d_fb;
  assign raddr[2] = d_add;
  assign raddr[3] = dbg_addr;

  mac_pair_rf #(.XLEN(XLEN), .NPORT(NPORT)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr),
    .wdata(rf_wdata), .raddr(raddr), .rdata(rdata)
  );

  mac_pair_madd #(.XLEN(XLEN)) u_madd (
    .fa(rdata[0]), .fb(rdata[1]), .addend(rdata[2]), .sum(sum_c)
  );

  assign in_ready  = (st_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign done      = done_q;
  assign illegal   = ill_q;
  assign dbg_rdata = rdata[3];

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = dbg_addr;
    rf_wdata = dbg_wdata;
    unique case (st_q)
      ST_WR_LO: begin
        rf_we    = 1'b1;
        rf_waddr = dst_q;
        rf_wdata = sum_q[XLEN-1:0];
      end
      ST_WR_HI: begin
        rf_we    = 1'b1;
        rf_waddr = dst_hi_q;
        rf_wdata = sum_q[SW-1:XLEN];
      end
      default: rf_we = dbg_we;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sum_q    <= '0;
      dst_q    <= '0;
      dst_hi_q <= '0;
      done_q   <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (d_legal) begin
            sum_q    <= sum_c;
            dst_q    <= d_dst;
            dst_hi_q <= d_dst_hi;
            st_q     <= ST_WR_LO;
          end else begin
            ill_q <= 1'b1;
          end
        end
        ST_WR_LO: st_q <= ST_WR_HI;
        ST_WR_HI: begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mac_pair_chk.sv
module mac_pair_chk
  import mac_pair_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             done,
  input logic             illegal,
  input logic             wr_lo,
  input logic             wr_hi,
  input logic [IDX_W-1:0] rf_waddr
);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (in_ready && $past(!in_ready)));

  p_lo_then_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> wr_hi);

  p_rs_follows_rt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |-> (rf_waddr == $past(rf_waddr) + IDX_W'(1)));

  p_illegal_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (in_ready && !wr_lo && !wr_hi));
endmodule

bind mac_pair_unit mac_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .done(done),
  .illegal(illegal), .wr_lo(st_q == mac_pair_pkg::ST_WR_LO),
  .wr_hi(st_q == mac_pair_pkg::ST_WR_HI), .rf_waddr(rf_waddr)
);

// File: tb/mac_pair_unit_bench.sv
`timescale 1ns/1ps
module mac_pair_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic        done, illegal;
  logic        dbg_we = 1'b0;
  logic [4:0]  dbg_addr = '0;
  logic [63:0] dbg_wdata = '0;
  logic [63:0] dbg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mac_pair_unit u_mac_pair_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .done(done), .illegal(illegal), .dbg_we(dbg_we),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 6;
  localparam logic [191:0] VEC [NV] = '{
    {64'd3, 64'd5, 64'd7},
    {ONES, ONES, ONES},
    {64'd0, 64'd1234, 64'h8000_0000_0000_0000},
    {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h1111_2222_3333_4444},
    {ONES, 64'd2, 64'd1},
    {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0}
  };

  function automatic logic [31:0] mk(input logic [5:0] p, input logic [4:0] d,
      input logic [4:0] a, input logic [4:0] b, input logic [4:0] c, input logic [5:0] x);
    return {p, d, a, b, c, x};
  endfunction

  function automatic logic [127:0] ref_sum(input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] c);
    logic [127:0] wa, wb, wc;
    wa = {64'd0, a}; wb = {64'd0, b}; wc = {64'd0, c};
    return wa * wb + wc;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic dwr(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk); dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk); dbg_we = 1'b0;
  endtask

  task automatic drd(input logic [4:0] a, output logic [63:0] d);
    dbg_addr = a; #1; d = dbg_rdata;
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk); in_valid = 1'b1; in_insn = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic run(input logic [31:0] w);
    issue(w);
    for (int k = 0; k < 8 && !done; k++) @(negedge clk);
  endtask

  initial begin
    logic [63:0] r, r2;
    logic [127:0] e, e2;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 ready", 64'(in_ready), 64'd1);
    chk("R11 done", 64'(done), 64'd0);
    chk("R11 illegal", 64'(illegal), 64'd0);
    drd(5'd7, r); chk("R11 reg zero", r, 64'd0);
    rst_n = 1'b1;

    // R10: debug preset and read back
    dwr(5'd9, 64'hDEAD_BEEF_0000_0009);
    drd(5'd9, r); chk("R10 debug write", r, 64'hDEAD_BEEF_0000_0009);

    // Vector table: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      dwr(5'd1, VEC[i][191:128]);
      dwr(5'd2, VEC[i][127:64]);
      dwr(5'd3, VEC[i][63:0]);
      run(mk(6'd4, 5'd10, 5'd1, 5'd2, 5'd3, 6'd50));
      e = ref_sum(VEC[i][191:128], VEC[i][127:64], VEC[i][63:0]);
      chk("R1 done", 64'(done), 64'd1);
      drd(5'd10, r); chk("R2 low half", r, e[63:0]);
      drd(5'd11, r); chk("R3 high half", r, e[127:64]);
    end
    drd(5'd11, r);
    // R3/R4 spot values from vectors 2 and 3 are covered above; explicit no-overflow case
    dwr(5'd1, ONES); dwr(5'd2, ONES); dwr(5'd3, ONES);
    run(mk(6'd4, 5'd14, 5'd1, 5'd2, 5'd3, 6'd50));
    drd(5'd15, r); chk("R3 max high", r, ONES);
    drd(5'd14, r); chk("R3 max low", r, 64'd0);
    dwr(5'd1, 64'd0); dwr(5'd3, 64'h8000_0000_0000_0001);
    run(mk(6'd4, 5'd14, 5'd1, 5'd2, 5'd3, 6'd50));
    drd(5'd15, r); chk("R4 zero extend high", r, 64'd0);
    drd(5'd14, r); chk("R4 zero extend low", r, 64'h8000_0000_0000_0001);

    // R5: destination overlaps sources (D=A=1, D+1=B=C=2)
    dwr(5'd1, 64'h0000_0001_0000_0003);
    dwr(5'd2, 64'hFFFF_0000_1234_5678);
    e = ref_sum(64'h0000_0001_0000_0003, 64'hFFFF_0000_1234_5678, 64'hFFFF_0000_1234_5678);
    run(mk(6'd4, 5'd1, 5'd1, 5'd2, 5'd2, 6'd50));
    drd(5'd1, r); chk("R5 overlap low", r, e[63:0]);
    drd(5'd2, r); chk("R5 overlap high", r, e[127:64]);

    // R6: chaining through the high half, back-to-back issue
    dwr(5'd1, ONES); dwr(5'd2, 64'hFFFF_FFFF_0000_0001); dwr(5'd3, 64'd77);
    dwr(5'd7, 64'h0F0F_0F0F_F0F0_F0F0);
    e  = ref_sum(ONES, 64'hFFFF_FFFF_0000_0001, 64'd77);
    e2 = ref_sum(ONES, 64'h0F0F_0F0F_F0F0_F0F0, e[127:64]);
    issue(mk(6'd4, 5'd4, 5'd1, 5'd2, 5'd3, 6'd50));
    run(mk(6'd4, 5'd6, 5'd1, 5'd7, 5'd5, 6'd50));
    drd(5'd4, r); chk("R6 first low", r, e[63:0]);
    drd(5'd6, r); chk("R6 chained low", r, e2[63:0]);
    drd(5'd7, r2); chk("R6 chained high", r2, e2[127:64]);

    // R7: D=31 rejected, registers 31 and 0 untouched
    dwr(5'd31, 64'h3131_3131_3131_3131); dwr(5'd0, 64'h0A0A_0A0A_0A0A_0A0A);
    issue(mk(6'd4, 5'd31, 5'd1, 5'd2, 5'd3, 6'd50));
    chk("R7 illegal pulse", 64'(illegal), 64'd1);
    chk("R7 ready kept", 64'(in_ready), 64'd1);
    @(negedge clk); chk("R7 illegal one cycle", 64'(illegal), 64'd0);
    repeat (3) @(negedge clk);
    chk("R7 no done", 64'(done), 64'd0);
    drd(5'd31, r); chk("R7 r31 kept", r, 64'h3131_3131_3131_3131);
    drd(5'd0, r);  chk("R7 r0 kept", r, 64'h0A0A_0A0A_0A0A_0A0A);

    // R8: wrong primary / extended opcode
    dwr(5'd20, 64'h2020_2020_2020_2020); dwr(5'd21, 64'h2121_2121_2121_2121);
    issue(mk(6'd5, 5'd20, 5'd1, 5'd2, 5'd3, 6'd50));
    chk("R8 bad primary illegal", 64'(illegal), 64'd1);
    issue(mk(6'd4, 5'd20, 5'd1, 5'd2, 5'd3, 6'd51));
    chk("R8 bad extended illegal", 64'(illegal), 64'd1);
    repeat (3) @(negedge clk);
    drd(5'd20, r); chk("R8 dest kept", r, 64'h2020_2020_2020_2020);
    drd(5'd21, r); chk("R8 dest+1 kept", r, 64'h2121_2121_2121_2121);

    // R9/R10: busy window, ignored word, ignored debug write
    dwr(5'd12, 64'h1212_1212_1212_1212);
    issue(mk(6'd4, 5'd16, 5'd1, 5'd2, 5'd3, 6'd50));
    chk("R9 busy 1", 64'(in_ready), 64'd0);
    chk("R9 no early done", 64'(done), 64'd0);
    in_valid = 1'b1; in_insn = mk(6'd4, 5'd12, 5'd1, 5'd2, 5'd3, 6'd50);
    dbg_we = 1'b1; dbg_addr = 5'd20; dbg_wdata = 64'h5555_5555_5555_5555;
    @(negedge clk);
    chk("R9 busy 2", 64'(in_ready), 64'd0);
    chk("R9 no done yet", 64'(done), 64'd0);
    in_valid = 1'b0; dbg_we = 1'b0;
    @(negedge clk);
    chk("R9 done pulse", 64'(done), 64'd1);
    chk("R9 ready back", 64'(in_ready), 64'd1);
    @(negedge clk);
    chk("R9 done one cycle", 64'(done), 64'd0);
    drd(5'd12, r); chk("R9 offered word ignored", r, 64'h1212_1212_1212_1212);
    drd(5'd20, r); chk("R10 busy debug write ignored", r, 64'h2020_2020_2020_2020);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule